// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table that lives in memory. A request carries a 20-bit virtual page number and an access kind. The upper ten bits of the page number select a pointer in the first-level table, whose base is taken from the root-base input. The lower ten bits then select a 32-bit entry in the second-level table that this pointer names. Both tables hold 1024 word-sized entries, and entry `i` of a table sits at `base + 4*i`.

The walker drives a single read port with a valid/ready request channel and a response that may come back after any number of cycles. Only one read is in flight at a time. The walk ends with a one-cycle result pulse. That pulse carries either a physical page number together with the entry's permission bits, or a fault code.

A pointer of zero means that no second-level table exists, and the walk then stops after one read. An entry whose present bit is clear is a missing page. An entry that is present but does not grant the requested access is a protection fault.

Top module: `ptw_walker`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `mem_req_valid` and `res_valid` are low.
- R2: The first read goes to `root + 4*VPN[19:10]`. The root is the value of `root_base` sampled in the cycle the request is accepted, and later changes to `root_base` do not affect the walk.
- R3: A non-zero first-level word is the base of the second-level table, and the second read goes to `pointer + 4*VPN[9:0]`.
- R4: A first-level word of zero ends the walk with fault code 1 (no table), after exactly one memory read.
- R5: A second-level entry with bit 0 (present) clear ends the walk with fault code 2 (not present), whatever its other bits hold.
- R6: Access code 0 (read) needs entry bit 2, code 1 (write) needs bit 3 and code 2 (execute) needs bit 4. Code 3 is reserved and is always refused. A present entry that refuses the access gives fault code 3 (protection).
- R7: A successful walk returns fault code 0, `res_ppn` = entry bits [31:12] and `res_perm` = entry bits [4:2] ordered {execute, write, read}. On any fault, `res_ppn` and `res_perm` are zero.
- R8: `busy` is high from the cycle after acceptance up to and including the single `res_valid` cycle. A request presented while `busy` is high, including during the result cycle, is dropped.
- R9: Once `mem_req_valid` is raised, it stays high with a stable `mem_req_addr` until a cycle in which `mem_req_ready` is high.
- R10: A `mem_rsp_valid` arriving while no read is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Start a walk (taken only when not busy) |
| req_vpn | input | 20 | Virtual page number to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| root_base | input | 32 | Byte address of the first-level table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_addr | output | 32 | Read byte address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| res_valid | output | 1 | One-cycle result pulse |
| res_fault | output | 2 | 0 ok, 1 no table, 2 not present, 3 protection |
| res_ppn | output | 20 | Physical page number on success |
| res_perm | output | 3 | Entry permissions {x, w, r} on success |

## Verification
A new request can arrive in the same cycle that the walker presents its result pulse. The walker is still busy in that cycle, so the request must be dropped rather than start a second walk. The bench raises `req_valid` exactly in the `res_valid` cycle and then checks that `busy` and `mem_req_valid` stay low in the following cycles. It also checks that the scoreboard receives no extra address and no extra result. A second overlap is tested the same way: a request during the first read is dropped. A stray memory response is also injected while the walker is idle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VPN_W   = 20;
    localparam int IDX_W   = 10;
    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 32;
    localparam int PPN_W   = 20;
    localparam int LEVELS  = 2;
    localparam int ENTRY_SHIFT = 2;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE        = 2'd0,
        FLT_NO_TABLE    = 2'd1,
        FLT_NOT_PRESENT = 2'd2,
        FLT_PERM        = 2'd3
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_st_e;

    function automatic logic [ADDR_W-1:0] entry_addr(
        input logic [ADDR_W-1:0] base,
        input logic [IDX_W-1:0]  idx
    );
        return base + ADDR_W'({idx, {ENTRY_SHIFT{1'b0}}});
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic              sel_l2,
    input  logic [ADDR_W-1:0] root,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] lvl_base [LEVELS];
    logic [ADDR_W-1:0] lvl_addr [LEVELS];

    assign lvl_base[0] = root;
    assign lvl_base[1] = ptr;

    // level 0 uses the top index field, each following level the next one down
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int HI = VPN_W - 1 - l * IDX_W;
        assign lvl_addr[l] = entry_addr(lvl_base[l], vpn[HI -: IDX_W]);
    end

    assign addr = sel_l2 ? lvl_addr[1] : lvl_addr[0];
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
(
    input  logic             pte_valid,
    input  logic [2:0]       pte_xwr,
    input  logic [PPN_W-1:0] pte_ppn,
    input  logic [1:0]       acc,
    output logic [1:0]       fault,
    output logic [PPN_W-1:0] ppn,
    output logic [2:0]       perm
);
    logic allow;

    always_comb begin
        case (acc)
            ACC_READ:  allow = pte_xwr[0];
            ACC_WRITE: allow = pte_xwr[1];
            ACC_EXEC:  allow = pte_xwr[2];
            default:   allow = 1'b0;
        endcase
    end

    always_comb begin
        if (!pte_valid)  fault = FLT_NOT_PRESENT;
        else if (!allow) fault = FLT_PERM;
        else             fault = FLT_NONE;
    end

    assign ppn  = (fault == FLT_NONE) ? pte_ppn : '0;
    assign perm = (fault == FLT_NONE) ? pte_xwr : '0;
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [1:0]        req_acc,
    input  logic [ADDR_W-1:0] root_base,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    input  logic [1:0]        chk_fault,
    input  logic [PPN_W-1:0]  chk_ppn,
    input  logic [2:0]        chk_perm,
    output logic              busy,
    output logic              mem_req_valid,
    output logic              sel_l2,
    output logic [VPN_W-1:0]  vpn_q,
    output logic [1:0]        acc_q,
    output logic [ADDR_W-1:0] root_q,
    output logic [ADDR_W-1:0] ptr_q,
    output logic              res_valid,
    output logic [1:0]        res_fault,
    output logic [PPN_W-1:0]  res_ppn,
    output logic [2:0]        res_perm
);
    walk_st_e state;

    assign busy          = (state != ST_IDLE);
    assign mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
    assign sel_l2        = (state == ST_L2_REQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            vpn_q     <= '0;
            acc_q     <= '0;
            root_q    <= '0;
            ptr_q     <= '0;
            res_valid <= 1'b0;
            res_fault <= '0;
            res_ppn   <= '0;
            res_perm  <= '0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        vpn_q  <= req_vpn;
                        acc_q  <= req_acc;
                        root_q <= root_base;
                        state  <= ST_L1_REQ;
                    end
                end
                ST_L1_REQ: begin
                    if (mem_req_ready) state <= ST_L1_WAIT;
                end
                ST_L1_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_data == '0) begin
                            res_fault <= FLT_NO_TABLE;
                            res_ppn   <= '0;
                            res_perm  <= '0;
                            res_valid <= 1'b1;
                            state     <= ST_DONE;
                        end else begin
                            ptr_q <= mem_rsp_data;
                            state <= ST_L2_REQ;
                        end
                    end
                end
                ST_L2_REQ: begin
                    if (mem_req_ready) state <= ST_L2_WAIT;
                end
                ST_L2_WAIT: begin
                    if (mem_rsp_valid) begin
                        res_fault <= chk_fault;
                        res_ppn   <= chk_ppn;
                        res_perm  <= chk_perm;
                        res_valid <= 1'b1;
                        state     <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid); // R9
    AST_RES_SINGLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R8
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req_valid && !res_valid); // R8
    AST_NULL_PTR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_L1_WAIT) && mem_rsp_valid && (mem_rsp_data == '0)
        |=> res_valid && (res_fault == FLT_NO_TABLE)); // R4
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        res_valid && (res_fault != FLT_NONE) |-> (res_ppn == '0) && (res_perm == '0)); // R7
    AST_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) && mem_rsp_valid && !req_valid |=> !busy); // R10
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [19:0] req_vpn,
    input  logic [1:0]  req_acc,
    input  logic [31:0] root_base,
    output logic        busy,
    output logic        mem_req_valid,
    output logic [31:0] mem_req_addr,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        res_valid,
    output logic [1:0]  res_fault,
    output logic [19:0] res_ppn,
    output logic [2:0]  res_perm
);
    logic              sel_l2;
    logic [VPN_W-1:0]  vpn_q;
    logic [1:0]        acc_q;
    logic [ADDR_W-1:0] root_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [1:0]        chk_fault;
    logic [PPN_W-1:0]  chk_ppn;
    logic [2:0]        chk_perm;

    ptw_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_vpn       (req_vpn),
        .req_acc       (req_acc),
        .root_base     (root_base),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .chk_fault     (chk_fault),
        .chk_ppn       (chk_ppn),
        .chk_perm      (chk_perm),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .sel_l2        (sel_l2),
        .vpn_q         (vpn_q),
        .acc_q         (acc_q),
        .root_q        (root_q),
        .ptr_q         (ptr_q),
        .res_valid     (res_valid),
        .res_fault     (res_fault),
        .res_ppn       (res_ppn),
        .res_perm      (res_perm)
    );

    ptw_addr_gen u_addr (
        .sel_l2 (sel_l2),
        .root   (root_q),
        .ptr    (ptr_q),
        .vpn    (vpn_q),
        .addr   (mem_req_addr)
    );

    // entry layout: [0] present, [1] dirty, [4:2] {x,w,r}, [31:12] page number
    ptw_pte_check u_chk (
        .pte_valid (mem_rsp_data[0]),
        .pte_xwr   (mem_rsp_data[4:2]),
        .pte_ppn   (mem_rsp_data[WORD_W-1 -: PPN_W]),
        .acc       (acc_q),
        .fault     (chk_fault),
        .ppn       (chk_ppn),
        .perm      (chk_perm)
    );

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr)); // R9
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;

    typedef struct {
        logic [1:0]  f;
        logic [19:0] ppn;
        logic [2:0]  perm;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [19:0] req_vpn;
    logic [1:0]  req_acc;
    logic [31:0] root_base;
    logic        busy;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        res_valid;
    logic [1:0]  res_fault;
    logic [19:0] res_ppn;
    logic [2:0]  res_perm;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit stall = 0;
    bit inject_stray = 0;
    int rsp_cnt = 0;
    logic [31:0] rsp_word;
    bit prev_stall = 0;
    logic [31:0] prev_addr;

    logic [31:0] mem [logic [31:0]];
    exp_t        exp_q [$];
    logic [31:0] addr_q [$];

    localparam logic [31:0] ROOT  = 32'h0010_0000;
    localparam logic [31:0] ROOT2 = 32'h0070_0000;
    localparam logic [31:0] TA    = 32'h0020_0000;
    localparam logic [31:0] TB    = 32'h0030_0000;

    always #2 clk = ~clk;

    ptw_walker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vpn(req_vpn),
        .req_acc(req_acc), .root_base(root_base), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
        .res_ppn(res_ppn), .res_perm(res_perm)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model and R9 request-hold monitor
    always @(negedge clk) begin
        cyc++;
        if (prev_stall)
            chk(mem_req_valid && (mem_req_addr == prev_addr), "R9", "request held",
                mem_req_addr, prev_addr);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'h0;
        if (rsp_cnt == 1) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rsp_word;
            rsp_cnt = 0;
        end else if (rsp_cnt > 1) begin
            rsp_cnt--;
        end else if (inject_stray) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = 32'h0000_1234;
            inject_stray  = 0;
        end
        mem_req_ready = stall ? (cyc % 3 == 0) : 1'b1;
        prev_stall = mem_req_valid && !mem_req_ready;
        prev_addr  = mem_req_addr;
        if (mem_req_valid && mem_req_ready) begin
            if (addr_q.size() == 0) begin
                chk(0, "R8", "unexpected read", mem_req_addr, 32'h0);
            end else begin
                logic [31:0] ea;
                ea = addr_q.pop_front();
                chk(mem_req_addr == ea, "R2/R3", "read address", mem_req_addr, ea);
            end
            rsp_word = rd(mem_req_addr);
            rsp_cnt  = 1 + (cyc % 4);
        end
    end

    // result scoreboard monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8", "unexpected result", {30'h0, res_fault}, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(res_fault == e.f, "R4/R5/R6", "fault code", {30'h0, res_fault}, {30'h0, e.f});
                chk(res_ppn == e.ppn, "R7", "ppn", {12'h0, res_ppn}, {12'h0, e.ppn});
                chk(res_perm == e.perm, "R7", "perm", {29'h0, res_perm}, {29'h0, e.perm});
                chk(addr_q.size() == 0, "R4", "reads issued", addr_q.size(), 32'h0);
            end
        end
    end

    task automatic walk(input logic [19:0] vpn, input logic [1:0] acc,
                        input logic [1:0] ef, input logic [19:0] eppn,
                        input logic [2:0] eperm, input bit swap_root, input bit poke);
        logic [31:0] a1, p;
        exp_t e;
        while (busy) @(negedge clk);
        a1 = root_base + {20'h0, vpn[19:10], 2'b00};
        p  = rd(a1);
        addr_q.push_back(a1);
        if (p != 0) addr_q.push_back(p + {20'h0, vpn[9:0], 2'b00});
        e.f = ef; e.ppn = eppn; e.perm = eperm;
        exp_q.push_back(e);
        req_valid = 1'b1; req_vpn = vpn; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8", "busy after accept", {31'h0, busy}, 32'h1);
        if (swap_root) root_base = ROOT2;     // R2: must not affect this walk
        if (poke) begin                       // R8: request while busy
            req_valid = 1'b1; req_vpn = 20'hFFFFF; req_acc = 2'd0;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) begin
            if (poke && res_valid) begin      // R8: request in the result cycle
                req_valid = 1'b1; req_vpn = 20'hFFFFF;
            end
            @(negedge clk);
            req_valid = 1'b0;
        end
        if (poke) begin
            repeat (2) begin
                chk(!busy && !mem_req_valid, "R8", "late request dropped",
                    {30'h0, busy, mem_req_valid}, 32'h0);
                @(negedge clk);
            end
        end
        root_base = ROOT;
        @(negedge clk);
    endtask

    initial begin
        mem[ROOT + 32'd20]   = TA;
        mem[ROOT + 32'd4092] = TB;
        mem[TA + 32'd28]     = {20'hABCDE, 7'd0, 5'b00101};
        mem[TA + 32'd32]     = {20'h12345, 7'd0, 5'b10001};
        mem[TA + 32'd36]     = {20'h55555, 7'd0, 5'b01110};
        mem[TB + 32'd4092]   = {20'hFFFFF, 7'd0, 5'b11111};
        rst = 1'b1; req_valid = 1'b0; req_vpn = '0; req_acc = '0;
        root_base = ROOT; mem_req_ready = 1'b1;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req_valid && !res_valid, "R1", "outputs in reset",
            {29'h0, busy, mem_req_valid, res_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req_valid && !res_valid, "R1", "outputs after reset",
            {29'h0, busy, mem_req_valid, res_valid}, 32'h0);

        walk({10'd5, 10'd7}, 2'd0, 2'd0, 20'hABCDE, 3'b001, 0, 0);    // R2 R3 R7 read ok
        walk({10'd5, 10'd7}, 2'd1, 2'd3, 20'h0, 3'b000, 0, 0);        // R6 write refused
        walk({10'd5, 10'd8}, 2'd2, 2'd0, 20'h12345, 3'b100, 0, 0);    // R6 exec ok
        walk({10'd5, 10'd8}, 2'd0, 2'd3, 20'h0, 3'b000, 0, 0);        // R6 read refused
        walk({10'd9, 10'd3}, 2'd0, 2'd1, 20'h0, 3'b000, 0, 0);        // R4 null pointer
        walk({10'd5, 10'd9}, 2'd1, 2'd2, 20'h0, 3'b000, 0, 0);        // R5 not present
        walk({10'd1023, 10'd1023}, 2'd3, 2'd3, 20'h0, 3'b000, 0, 0);  // R6 reserved code
        stall = 1;
        walk({10'd1023, 10'd1023}, 2'd1, 2'd0, 20'hFFFFF, 3'b111, 0, 0); // R9 top indices
        walk({10'd5, 10'd7}, 2'd0, 2'd0, 20'hABCDE, 3'b001, 1, 0);    // R2 root swap
        stall = 0;
        walk({10'd5, 10'd8}, 2'd2, 2'd0, 20'h12345, 3'b100, 0, 1);    // R8 pokes

        inject_stray = 1;                                              // R10
        repeat (4) begin
            @(negedge clk);
            chk(!busy && !res_valid, "R10", "stray response ignored",
                {30'h0, busy, res_valid}, 32'h0);
        end
        chk(exp_q.size() == 0 && addr_q.size() == 0, "R8", "scoreboard drained",
            exp_q.size() + addr_q.size(), 32'h0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R8 watchdog expired: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule